// File: doc/BRIEF.md
# Weighted Pseudo-Random Pattern Generator

This block produces an N-bit test pattern every clock in which each bit has a chosen probability of being 1. A plain shift-register sequence gives every bit a one-in-two chance of being 1. That makes a wide AND cone very unlikely to reach 1, and a very long run of patterns is then needed to exercise it. Here a maximal-length linear feedback shift register supplies raw bits. For each output bit, a 2-bit weight code decides how many distinct raw stages are ANDed together, from one to four. A per-bit invert flag can then complement the result. The probabilities available are 1/2, 1/4, 1/8 and 1/16, and with inversion 1/2, 3/4, 7/8 and 15/16.

A small table holds up to three weight sets, written through a simple write port. A registered set-select input picks which set shapes the pattern. A test controller seeds the register, loads one or more weight sets, and then runs the generator with the enable held high. It can switch between sets between phases of a test run.

Top module: `wpat_gen`

## Requirements
- R1: After reset the shift register holds 0x00000001, every set has code 00 with invert 0, and set 0 is active, so `pattern_o` reads 0x01.
- R2: When `seed_ld_i` is high at a clock edge, the register takes `seed_i` at that edge, whatever `en_i` is. A zero seed is replaced by 0x00000001.
- R3: When `en_i` is high and `seed_ld_i` is low, the register shifts one place toward its MSB. The new bit 0 is the XOR of stages 31, 21, 1 and 0, which implements x^32+x^22+x^2+x+1.
- R4: When both `en_i` and `seed_ld_i` are low, the register and the pattern hold.
- R5: Output bit j draws its raw bits from stages j, j+8, j+16 and j+24, in that order of use.
- R6: Weight code c of output j sits in `cfg_code_i[2j+1:2j]`. Code 00 passes the first raw bit, 01 ANDs the first two, 10 the first three and 11 all four.
- R7: Invert flag j (`cfg_inv_i[j]`) set to 1 complements output bit j after the AND.
- R8: `cfg_we_i` stores the code and invert vectors into set `cfg_set_i` at the clock edge. A write to index 3 is ignored and leaves sets 0 to 2 unchanged.
- R9: `set_sel_i` is registered, so a new selection shapes the pattern from the next clock onward. The value 3 selects set 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seed_ld_i | input | 1 | Load `seed_i` into the shift register |
| seed_i | input | 32 | Seed value |
| en_i | input | 1 | Advance the shift register one step |
| cfg_we_i | input | 1 | Write the weight table |
| cfg_set_i | input | 2 | Weight set index to write |
| cfg_code_i | input | 16 | Weight codes, 2 bits per output |
| cfg_inv_i | input | 8 | Invert flags, 1 bit per output |
| set_sel_i | input | 2 | Active weight set select |
| pattern_o | output | 8 | Weighted pattern |

## Verification
The assertions assume every control input is a known value at each rising edge. They also assume a written weight set is read only after the edge that stores it. The nonzero-register check depends on the zero-seed substitution, not on the driver avoiding zero, so the stimulus deliberately loads a zero seed. All inputs change only on falling edges, and the select input is driven to the out-of-range value 3, so the select-range check is exercised.

// File: rtl/wpat_pkg.sv
package wpat_pkg;
  typedef enum logic [1:0] {
    WC_ONE   = 2'b00,
    WC_TWO   = 2'b01,
    WC_THREE = 2'b10,
    WC_FOUR  = 2'b11
  } wcode_e;
endpackage

// File: rtl/wpat_lfsr.sv
module wpat_lfsr #(
  parameter int unsigned         W        = 32,
  parameter logic [W-1:0]        TAPS     = 32'h8020_0003,
  parameter logic [W-1:0]        RST_SEED = 32'h0000_0001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         seed_ld_i,
  input  logic [W-1:0] seed_i,
  input  logic         en_i,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] ZERO_FIX = W'(1);

  logic [W-1:0] state_q, state_d;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_comb begin
    state_d = state_q;
    if (seed_ld_i)   state_d = (seed_i == '0) ? ZERO_FIX : seed_i;
    else if (en_i)   state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RST_SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_never_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  assert_seed_taken_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_ld_i && seed_i != '0) |=> state_q == $past(seed_i));
  assert_shift_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !seed_ld_i) |=> state_q[W-1:1] == $past(state_q[W-2:0]));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !seed_ld_i) |=> $stable(state_q));
endmodule

// File: rtl/wpat_wtable.sv
module wpat_wtable #(
  parameter int unsigned N_OUT    = 8,
  parameter int unsigned NUM_SETS = 3,
  parameter int unsigned SEL_W    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [SEL_W-1:0]   wset_i,
  input  logic [2*N_OUT-1:0] code_i,
  input  logic [N_OUT-1:0]   inv_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [2*N_OUT-1:0] code_o,
  output logic [N_OUT-1:0]   inv_o
);
  logic [2*N_OUT-1:0] code_q [NUM_SETS];
  logic [N_OUT-1:0]   inv_q  [NUM_SETS];
  logic [SEL_W-1:0]   act_q;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q[s] <= '0;
        inv_q[s]  <= '0;
      end else if (we_i && wset_i == SEL_W'(s)) begin
        code_q[s] <= code_i;
        inv_q[s]  <= inv_i;
      end
    end

    assert_set_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wset_i == SEL_W'(s)) |=> (code_q[s] == $past(code_i) && inv_q[s] == $past(inv_i)));
    assert_set_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && wset_i == SEL_W'(s)) |=> ($stable(code_q[s]) && $stable(inv_q[s])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     act_q <= '0;
    else if (32'(sel_i) < NUM_SETS)  act_q <= sel_i;
    else                             act_q <= '0;
  end

  assign code_o = code_q[act_q];
  assign inv_o  = inv_q[act_q];

  assert_sel_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(act_q) < NUM_SETS);
  assert_sel_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(sel_i) < NUM_SETS) |=> act_q == $past(sel_i));
endmodule

// File: rtl/wpat_shaper.sv
module wpat_shaper
  import wpat_pkg::*;
#(
  parameter int unsigned N_OUT = 8,
  parameter int unsigned W     = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [W-1:0]       raw_i,
  input  logic [2*N_OUT-1:0] code_i,
  input  logic [N_OUT-1:0]   inv_i,
  output logic [N_OUT-1:0]   pat_o
);
  localparam int unsigned TAKE = 4;

  for (genvar j = 0; j < N_OUT; j++) begin : g_bit
    logic [TAKE-1:0] r;
    wcode_e          c;
    logic            andv;

    for (genvar k = 0; k < TAKE; k++) begin : g_tap
      assign r[k] = raw_i[j + k*N_OUT];
    end

    assign c = wcode_e'(code_i[2*j +: 2]);

    always_comb begin
      unique case (c)
        WC_ONE:   andv = r[0];
        WC_TWO:   andv = &r[1:0];
        WC_THREE: andv = &r[2:0];
        default:  andv = &r[3:0];
      endcase
    end

    assign pat_o[j] = andv ^ inv_i[j];

    assert_and_four_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c == WC_FOUR && !inv_i[j] && pat_o[j]) |-> (&raw_i[j] && raw_i[j+N_OUT] && raw_i[j+2*N_OUT] && raw_i[j+3*N_OUT]));
    assert_zero_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inv_i[j] && !raw_i[j]) |-> !pat_o[j]);
    assert_invert_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c == WC_ONE && inv_i[j]) |-> pat_o[j] != raw_i[j]);
  end
endmodule

// File: rtl/wpat_gen.sv
module wpat_gen #(
  parameter int unsigned N_OUT    = 8,
  parameter int unsigned NUM_SETS = 3,
  parameter int unsigned LFSR_W   = 32,
  parameter logic [LFSR_W-1:0] TAPS     = 32'h8020_0003,
  parameter logic [LFSR_W-1:0] RST_SEED = 32'h0000_0001,
  localparam int unsigned SEL_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS + 1) : 1,
  localparam int unsigned CODE_W = 2 * N_OUT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_ld_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              en_i,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_set_i,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic [N_OUT-1:0]  cfg_inv_i,
  input  logic [SEL_W-1:0]  set_sel_i,
  output logic [N_OUT-1:0]  pattern_o
);
  logic [LFSR_W-1:0] state;
  logic [CODE_W-1:0] act_code;
  logic [N_OUT-1:0]  act_inv;

  wpat_lfsr #(.W(LFSR_W), .TAPS(TAPS), .RST_SEED(RST_SEED)) u_lfsr (
    .clk_i, .rst_ni, .seed_ld_i, .seed_i, .en_i, .state_o(state)
  );

  wpat_wtable #(.N_OUT(N_OUT), .NUM_SETS(NUM_SETS), .SEL_W(SEL_W)) u_wtable (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .wset_i(cfg_set_i), .code_i(cfg_code_i), .inv_i(cfg_inv_i),
    .sel_i(set_sel_i), .code_o(act_code), .inv_o(act_inv)
  );

  wpat_shaper #(.N_OUT(N_OUT), .W(LFSR_W)) u_shaper (
    .clk_i, .rst_ni, .raw_i(state), .code_i(act_code), .inv_i(act_inv), .pat_o(pattern_o)
  );

  // R5: stage reach of the widest AND must stay inside the register
  initial assert_reach_R5: assert (4 * N_OUT <= LFSR_W);
endmodule

// File: tb/wpat_gen_bench.sv
module wpat_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        seed_ld_i = 1'b0;
  logic [31:0] seed_i = '0;
  logic        en_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_set_i = '0;
  logic [15:0] cfg_code_i = '0;
  logic [7:0]  cfg_inv_i = '0;
  logic [1:0]  set_sel_i = '0;
  logic [7:0]  pattern_o;

  int n_run = 0;
  int n_fail = 0;

  logic [31:0] m_lfsr;
  logic [15:0] m_code [3];
  logic [7:0]  m_inv  [3];
  int          m_act;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk_i = ~clk_i;

  wpat_gen u_wpat_gen (.*);

  function automatic logic [7:0] shape(logic [31:0] s, logic [15:0] c, logic [7:0] v);
    logic [7:0] o;
    for (int j = 0; j < 8; j++) begin
      logic r;
      int   cc;
      cc = int'(c[2*j +: 2]);
      r = s[j];
      if (cc >= 1) r = r & s[j+8];
      if (cc >= 2) r = r & s[j+16];
      if (cc >= 3) r = r & s[j+24];
      o[j] = r ^ v[j];
    end
    return o;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: pattern got %h expected %h", tag, got, exp);
    end
  endtask

  // driver: apply the current inputs across one rising edge, queue the expectation
  task automatic tick(string tag);
    if (seed_ld_i) m_lfsr = (seed_i == 0) ? 32'h1 : seed_i;
    else if (en_i) m_lfsr = {m_lfsr[30:0], m_lfsr[31] ^ m_lfsr[21] ^ m_lfsr[1] ^ m_lfsr[0]};
    if (cfg_we_i && cfg_set_i < 3) begin
      m_code[cfg_set_i] = cfg_code_i;
      m_inv[cfg_set_i]  = cfg_inv_i;
    end
    m_act = (set_sel_i < 3) ? int'(set_sel_i) : 0;
    exp_q.push_back(shape(m_lfsr, m_code[m_act], m_inv[m_act]));
    tag_q.push_back(tag);
    @(negedge clk_i);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), pattern_o, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_lfsr = 32'h1;
    for (int s = 0; s < 3; s++) begin m_code[s] = '0; m_inv[s] = '0; end
    m_act = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1", pattern_o, 8'h01);

    // R3/R5: free-run with code 00 everywhere
    en_i = 1'b1;
    run(40, "R3");
    // R4: hold
    en_i = 1'b0;
    run(5, "R4");
    // R2: load wins over enable, then a zero seed
    en_i = 1'b1; seed_ld_i = 1'b1; seed_i = 32'hDEAD_BEEF;
    tick("R2");
    seed_ld_i = 1'b0;
    run(10, "R3");
    seed_ld_i = 1'b1; seed_i = 32'h0;
    tick("R2");
    seed_ld_i = 1'b0;
    run(10, "R2");
    seed_ld_i = 1'b1; seed_i = 32'hFFFF_FFFF; en_i = 1'b0;
    tick("R2");
    seed_ld_i = 1'b0;
    run(3, "R4");

    // R8: write set 1 while set 0 is active, nothing visible yet
    cfg_we_i = 1'b1; cfg_set_i = 2'd1; cfg_code_i = 16'b11_10_01_00_11_10_01_00; cfg_inv_i = 8'h00;
    tick("R8");
    cfg_we_i = 1'b0;
    // R9: select set 1, takes effect after the edge
    set_sel_i = 2'd1;
    tick("R9");
    en_i = 1'b1;
    run(60, "R6");
    // R7: inverted mix in set 2
    cfg_we_i = 1'b1; cfg_set_i = 2'd2; cfg_code_i = 16'b00_01_10_11_00_01_10_11; cfg_inv_i = 8'hA5;
    tick("R8");
    cfg_we_i = 1'b0; set_sel_i = 2'd2;
    run(60, "R7");
    // R5: all-four AND with all-ones seed marks every stage
    cfg_we_i = 1'b1; cfg_set_i = 2'd0; cfg_code_i = 16'hFFFF; cfg_inv_i = 8'h00;
    tick("R8");
    cfg_we_i = 1'b0; set_sel_i = 2'd0; seed_ld_i = 1'b1; seed_i = 32'hFFFF_FFFF;
    tick("R5");
    seed_ld_i = 1'b1; seed_i = 32'h0100_0000;
    tick("R5");
    seed_ld_i = 1'b0;
    run(60, "R5");
    // R9: select 3 falls back to set 0
    set_sel_i = 2'd3;
    run(20, "R9");
    // R8: write to index 3 is dropped
    cfg_we_i = 1'b1; cfg_set_i = 2'd3; cfg_code_i = 16'h5555; cfg_inv_i = 8'hFF;
    tick("R8");
    cfg_we_i = 1'b0;
    for (int s = 0; s < 3; s++) begin
      set_sel_i = 2'(s);
      run(15, "R8");
    end
    // long mixed run over all sets
    for (int s = 0; s < 4; s++) begin
      set_sel_i = 2'(s);
      run(500, "R6");
    end

    repeat (3) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule